// File: doc/BRIEF.md
# Multichannel Streaming Pattern Checker

This block sits at the end of a streaming path and checks packetized traffic that arrives on several interleaved channels. Each beat carries a fixed number of 8-bit symbols together with a channel number, start and end markers and an error sideband. Within a packet, every channel is expected to carry a count that starts at zero and goes up by one per symbol. The block flags symbols that break this count and beats that break the framing. Each violation goes into a small queue of exception records. For each channel it keeps saturating counts of packets, symbols and beats with bad data.

Software controls the block through a 32-bit register port with word addresses. Reads return one cycle after the request. The port gives the block's identity, an enable and a throttle setting, and a soft clear. Exception records are read one at a time. Per-channel counts are read by first selecting a channel. The throttle sets how often the input accepts beats, using a 16-bit pseudo-random sequence. It is meant for stressing the upstream sender with back-pressure.

Top module: `stream_pattern_checker`

## Requirements
- R1: Word address 0 reads the constant 32'h8204_0065: identity 16'h0065 in bits 15:0, the channel count (4) in bits 23:16, the symbols per beat (2) in bits 30:24, and bit 31 set because packets are supported. Read data appears on `reg_rdata` one cycle after `reg_read`.
- R2: Word address 1 is the control register and reads back what was written: bit 0 enables acceptance, bits 16:8 hold the throttle (0..256) and bit 17 is the soft clear. All other bits read 0.
- R3: While enable is 0 or the throttle is 0, `in_ready` stays low.
- R4: With enable set and the throttle at 256, `in_ready` is high on every cycle. A beat is taken on any rising edge where `in_valid` and `in_ready` are both high.
- R5: With enable set and the throttle at 128, `in_ready` is high on roughly half of the cycles. The bench accepts 35% to 65%.
- R6: The expected pattern restarts at 0 on a start-of-packet beat and otherwise continues from the channel's previous beat. Symbol lane i (bits 8i+7:8i) must equal base+i. A beat with any wrong lane raises a data error.
- R7: A beat on a channel that is outside a packet and has no start-of-packet raises a missing-start exception. Any accepted beat without end-of-packet leaves the channel inside a packet.
- R8: A start-of-packet beat on a channel that is still inside a packet raises a missing-end exception.
- R9: Word address 5 pops the oldest exception record. The record holds bit 0 data error, bit 1 missing start, bit 2 missing end, bits 15:8 the error sideband and bits 31:24 the channel. The address reads 0 when the queue is empty.
- R10: The queue holds 4 records. Exceptions that arrive while it is full are dropped, and the older records are kept.
- R11: Writing a channel to bits 7:0 of word address 6 selects it. Address 6 bits 31:16 then return that channel's data-error beat count. Address 7 returns its packet count (end-of-packet beats) in bits 15:0 and its symbol count in bits 31:16.
- R12: The per-channel counts stop at 16'hFFFF instead of wrapping.
- R13: While the soft clear bit is 1, all counts, packet states and queued exceptions are cleared and held at zero, and `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present on the stream input |
| in_ready | output | 1 | Throttled acceptance, registered |
| in_data | input | 16 | Symbols, lane 0 in the low byte |
| in_channel | input | 2 | Channel of the beat |
| in_sop | input | 1 | Start-of-packet marker |
| in_eop | input | 1 | End-of-packet marker |
| in_error | input | 8 | Error sideband stored with exceptions |
| reg_addr | input | 3 | Word address of the register access |
| reg_write | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_read | input | 1 | Read strobe; address 5 pops the queue |
| reg_rdata | output | 32 | Read data, valid one cycle after the strobe |

## Verification
An accepted beat updates the channel state, the counts and the queue on the same edge that takes it, so a register read issued in the next cycle already sees the result. The bench drives inputs on falling edges and waits for `in_ready` there, which tells it the edge on which a beat is taken. It samples `reg_rdata` one falling edge after it raises `reg_read`, which matches the one-cycle read latency. Control writes reach `in_ready` two edges later, one edge for the register and one for the registered ready. The bench therefore waits for ready instead of counting cycles.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam logic [2:0] ADR_STATUS = 3'd0;
  localparam logic [2:0] ADR_CTRL   = 3'd1;
  localparam logic [2:0] ADR_EXC    = 3'd5;
  localparam logic [2:0] ADR_SEL    = 3'd6;
  localparam logic [2:0] ADR_COUNT  = 3'd7;
  localparam logic [15:0] IDENT     = 16'h0065;

  typedef struct packed {
    logic [7:0] chan;
    logic [7:0] err;
    logic       miss_eop;
    logic       miss_sop;
    logic       data_err;
  } exc_t;
endpackage

// File: rtl/spc_throttle.sv
module spc_throttle #(
  parameter int          THR_W = 9,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hold,
  input  logic [THR_W-1:0] thr,
  output logic             ready
);
  localparam int LW = 16;
  logic [LW-1:0] lfsr;
  logic          fb;
  logic          grant;

  assign fb    = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  assign grant = en && !hold && (THR_W'({1'b0, lfsr[7:0]}) + THR_W'(1) <= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr  <= SEED;
      ready <= 1'b0;
    end else begin
      lfsr  <= {lfsr[LW-2:0], fb};
      ready <= grant;
    end
  end

  // R3
  off_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ready);
  // R5
  lfsr_alive_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

// File: rtl/spc_exc_fifo.sv
module spc_exc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R10
  fill_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (cnt == (AW+1)'(DEPTH)) && $stable(wp));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/spc_tracker.sv
module spc_tracker
  import spc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SPB    = 2,
  parameter int SYM_W  = 8,
  parameter int ERR_W  = 8,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DW    = SPB * SYM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             beat,
  input  logic [CH_W-1:0]  ch,
  input  logic             sop,
  input  logic             eop,
  input  logic [DW-1:0]    data,
  input  logic [ERR_W-1:0] err,
  input  logic [7:0]       sel,
  output logic [CNT_W-1:0] sel_pkts,
  output logic [CNT_W-1:0] sel_syms,
  output logic [CNT_W-1:0] sel_errs,
  output logic             exc_push,
  output exc_t             exc_rec
);
  logic             in_pkt  [NUM_CH];
  logic [SYM_W-1:0] nxt_sym [NUM_CH];
  logic [CNT_W-1:0] pkts    [NUM_CH];
  logic [CNT_W-1:0] syms    [NUM_CH];
  logic [CNT_W-1:0] errs    [NUM_CH];

  logic [SYM_W-1:0] base;
  logic             mism, msop, meop, sel_ok;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic [CNT_W-1:0] d);
    logic [CNT_W:0] s;
    s = {1'b0, v} + {1'b0, d};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_comb begin
    base = sop ? '0 : nxt_sym[ch];
    mism = 1'b0;
    for (int i = 0; i < SPB; i++) begin
      if (data[i*SYM_W +: SYM_W] != base + SYM_W'(i)) mism = 1'b1;
    end
    msop = !in_pkt[ch] && !sop;
    meop = in_pkt[ch] && sop;
  end

  assign exc_push         = beat && (mism || msop || meop);
  assign exc_rec.chan     = 8'(ch);
  assign exc_rec.err      = 8'(err);
  assign exc_rec.miss_eop = meop;
  assign exc_rec.miss_sop = msop;
  assign exc_rec.data_err = mism;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (rst || clr) begin
        in_pkt[c]  <= 1'b0;
        nxt_sym[c] <= '0;
        pkts[c]    <= '0;
        syms[c]    <= '0;
        errs[c]    <= '0;
      end else if (beat && ch == CH_W'(c)) begin
        in_pkt[c]  <= !eop;
        nxt_sym[c] <= base + SYM_W'(SPB);
        syms[c]    <= sat_inc(syms[c], CNT_W'(SPB));
        if (eop)  pkts[c] <= sat_inc(pkts[c], CNT_W'(1));
        if (mism) errs[c] <= sat_inc(errs[c], CNT_W'(1));
      end
    end
  end

  assign sel_ok   = (32'(sel) < NUM_CH);
  assign sel_pkts = sel_ok ? pkts[sel[CH_W-1:0]] : '0;
  assign sel_syms = sel_ok ? syms[sel[CH_W-1:0]] : '0;
  assign sel_errs = sel_ok ? errs[sel[CH_W-1:0]] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt_chk
    // R12
    sym_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (syms[g] == '1 && !clr) |=> syms[g] == '1);
    // R12
    pkt_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (pkts[g] == '1 && !clr) |=> pkts[g] == '1);
    // R13
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (pkts[g] == '0 && syms[g] == '0 && errs[g] == '0 && !in_pkt[g]));
  end
endmodule

// File: rtl/stream_pattern_checker.sv
module stream_pattern_checker
  import spc_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SPB       = 2,
  parameter int SYM_W     = 8,
  parameter int ERR_W     = 8,
  parameter int CNT_W     = 16,
  parameter int EXC_DEPTH = 4,
  parameter bit HAS_PKT   = 1'b1,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DW       = SPB * SYM_W,
  localparam int THR_W    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [CH_W-1:0]  in_channel,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [ERR_W-1:0] in_error,
  input  logic [2:0]       reg_addr,
  input  logic             reg_write,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_read,
  output logic [31:0]      reg_rdata
);
  logic             en_q, clr_q;
  logic [THR_W-1:0] thr_q;
  logic [7:0]       sel_q;
  logic             beat, exc_push, q_empty, q_pop;
  exc_t             exc_rec, q_head;
  logic [CNT_W-1:0] sel_pkts, sel_syms, sel_errs;
  logic [31:0]      status_w;

  assign beat     = in_valid && in_ready;
  assign q_pop    = reg_read && reg_addr == ADR_EXC;
  assign status_w = {HAS_PKT, 7'(SPB), 8'(NUM_CH), IDENT};

  spc_throttle #(.THR_W(THR_W)) u_thr (
    .clk(clk), .rst(rst), .en(en_q), .hold(clr_q), .thr(thr_q), .ready(in_ready)
  );

  spc_tracker #(
    .NUM_CH(NUM_CH), .SPB(SPB), .SYM_W(SYM_W), .ERR_W(ERR_W), .CNT_W(CNT_W)
  ) u_trk (
    .clk(clk), .rst(rst), .clr(clr_q), .beat(beat), .ch(in_channel),
    .sop(in_sop), .eop(in_eop), .data(in_data), .err(in_error), .sel(sel_q),
    .sel_pkts(sel_pkts), .sel_syms(sel_syms), .sel_errs(sel_errs),
    .exc_push(exc_push), .exc_rec(exc_rec)
  );

  spc_exc_fifo #(.DEPTH(EXC_DEPTH), .W($bits(exc_t))) u_exq (
    .clk(clk), .rst(rst), .clr(clr_q), .push(exc_push), .din(exc_rec),
    .pop(q_pop), .dout(q_head), .empty(q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
      thr_q <= '0;
      sel_q <= '0;
    end else if (reg_write) begin
      if (reg_addr == ADR_CTRL) begin
        en_q  <= reg_wdata[0];
        thr_q <= reg_wdata[16:8];
        clr_q <= reg_wdata[17];
      end
      if (reg_addr == ADR_SEL) sel_q <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_read) begin
      case (reg_addr)
        ADR_STATUS: reg_rdata <= status_w;
        ADR_CTRL:   reg_rdata <= {14'd0, clr_q, thr_q, 7'd0, en_q};
        ADR_EXC:    reg_rdata <= q_empty ? '0 :
                                 {q_head.chan, 8'd0, q_head.err, 5'd0,
                                  q_head.miss_eop, q_head.miss_sop, q_head.data_err};
        ADR_SEL:    reg_rdata <= {16'(sel_errs), 8'd0, sel_q};
        ADR_COUNT:  reg_rdata <= {16'(sel_syms), 16'(sel_pkts)};
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R13
  clr_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !in_ready);
  // R1
  status_const_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_read && reg_addr == ADR_STATUS) |=> reg_rdata[15:0] == IDENT);
endmodule

// File: tb/sim_stream_pattern_checker.sv
module sim_stream_pattern_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [1:0]  in_channel = '0;
  logic        in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_error = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_write = 1'b0, reg_read = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stream_pattern_checker u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_channel(in_channel), .in_sop(in_sop), .in_eop(in_eop),
    .in_error(in_error), .reg_addr(reg_addr), .reg_write(reg_write),
    .reg_wdata(reg_wdata), .reg_read(reg_read), .reg_rdata(reg_rdata)
  );

  // fields: ch[30:29] sop[28] eop[27] err[26:19] lane0[18:11] lane1[10:3] flags[2:0]
  localparam int NV = 11;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 3'b000},
    {2'd0, 1'b0, 1'b0, 8'h00, 8'h02, 8'h03, 3'b000},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'h04, 8'h05, 3'b000},
    {2'd1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h01, 3'b000},
    {2'd2, 1'b1, 1'b0, 8'h11, 8'h00, 8'h07, 3'b001},
    {2'd2, 1'b0, 1'b1, 8'h00, 8'h02, 8'h03, 3'b000},
    {2'd3, 1'b0, 1'b0, 8'h22, 8'h00, 8'h01, 3'b010},
    {2'd3, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 3'b100},
    {2'd3, 1'b0, 1'b1, 8'h00, 8'h02, 8'h03, 3'b000},
    {2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 3'b000},
    {2'd1, 1'b0, 1'b1, 8'h5A, 8'h05, 8'h03, 3'b001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_write = 1'b1;
    @(negedge clk);
    reg_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_read = 1'b1;
    @(negedge clk);
    reg_read = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send(input logic [1:0] ch, input logic sop, input logic eop,
                      input logic [7:0] err, input logic [7:0] l0, input logic [7:0] l1);
    in_channel = ch; in_sop = sop; in_eop = eop; in_error = err;
    in_data = {l1, l0}; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic counts(input logic [7:0] ch, output logic [31:0] sel_v, output logic [31:0] cnt_v);
    wr(3'd6, {24'd0, ch});
    rd(3'd6, sel_v);
    rd(3'd7, cnt_v);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s, c;
    logic [31:0] exp_q [4];
    int qn;
    int e_pk [4], e_sy [4], e_er [4];
    int hits;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    check("R3 reset ready", {31'd0, in_ready}, 32'd0);
    rd(3'd0, d); check("R1 status", d, 32'h8204_0065);
    rd(3'd1, d); check("R2 ctrl reset", d, 32'd0);
    rd(3'd5, d); check("R9 empty queue", d, 32'd0);
    counts(8'd2, s, c); check("R11 reset count", c, 32'd0);

    // Disabled with full throttle: never ready
    wr(3'd1, 32'h0001_0000);
    hits = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); hits += in_ready; end
    check("R3 disabled", hits, 0);

    // Enabled with zero throttle
    wr(3'd1, 32'h0000_0001);
    hits = 0;
    for (int i = 0; i < 500; i++) begin @(negedge clk); hits += in_ready; end
    check("R3 zero throttle", hits, 0);

    // Half throttle
    wr(3'd1, 32'h0000_8001);
    @(negedge clk);
    hits = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); hits += in_ready; end
    check("R5 half rate", {31'd0, (hits >= 700 && hits <= 1300)}, 32'd1);

    // Full throttle
    wr(3'd1, 32'h0001_0001);
    rd(3'd1, d); check("R2 ctrl readback", d, 32'h0001_0001);
    hits = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); hits += in_ready; end
    check("R4 full rate", hits, 300);

    // Vector table walk (R6, R7, R8)
    qn = 0;
    for (int k = 0; k < 4; k++) begin e_pk[k] = 0; e_sy[k] = 0; e_er[k] = 0; end
    for (int v = 0; v < NV; v++) begin
      logic [30:0] t;
      t = VEC[v];
      send(t[30:29], t[28], t[27], t[26:19], t[18:11], t[10:3]);
      e_sy[t[30:29]] += 2;
      if (t[27]) e_pk[t[30:29]]++;
      if (t[0])  e_er[t[30:29]]++;
      if (t[2:0] != 3'b000 && qn < 4) begin
        exp_q[qn] = {6'd0, t[30:29], 8'd0, t[26:19], 5'd0, t[2:0]};
        qn++;
      end
    end
    // Overflow beat: ch0 outside a packet without start, lanes match 6,7
    send(2'd0, 1'b0, 1'b0, 8'h33, 8'h06, 8'h07);
    e_sy[0] += 2;
    idle();

    check("R10 queue model full", qn, 4);
    rd(3'd5, d); check("R6 R9 data error record", d, exp_q[0]);
    rd(3'd5, d); check("R7 missing start record", d, exp_q[1]);
    rd(3'd5, d); check("R8 missing end record", d, exp_q[2]);
    rd(3'd5, d); check("R10 oldest kept, overflow dropped", d, exp_q[3]);
    rd(3'd5, d); check("R9 drained reads zero", d, 32'd0);

    for (int k = 0; k < 4; k++) begin
      counts(8'(k), s, c);
      check("R11 error count", {16'd0, s[31:16]}, 32'(e_er[k]));
      check("R11 select echo", {24'd0, s[7:0]}, 32'(k));
      check("R11 packet count", {16'd0, c[15:0]}, 32'(e_pk[k]));
      check("R11 symbol count", {16'd0, c[31:16]}, 32'(e_sy[k]));
    end
    counts(8'd9, s, c);
    check("R11 out of range select", c, 32'd0);

    // ch0 is inside a packet now: start gives missing end, then soft clear
    send(2'd0, 1'b1, 1'b1, 8'h44, 8'h00, 8'h01);
    idle();
    wr(3'd1, 32'h0003_0001);
    @(negedge clk);
    check("R13 ready held low", {31'd0, in_ready}, 32'd0);
    rd(3'd5, d); check("R13 queue cleared", d, 32'd0);
    counts(8'd1, s, c);
    check("R13 counts cleared", c, 32'd0);
    check("R13 errors cleared", {16'd0, s[31:16]}, 32'd0);
    wr(3'd1, 32'h0001_0001);

    // After clear ch0 is outside a packet: clean start produces no exception
    send(2'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01);
    send(2'd0, 1'b0, 1'b1, 8'h00, 8'h02, 8'h03);
    idle();
    rd(3'd5, d); check("R13 state cleared", d, 32'd0);
    wr(3'd1, 32'h0003_0001);
    wr(3'd1, 32'h0001_0001);

    // Saturation on ch0
    for (int i = 0; i < 32769; i++) send(2'd0, 1'b1, 1'b1, 8'h00, 8'h00, 8'h01);
    idle();
    counts(8'd0, s, c);
    check("R12 symbol count saturates", {16'd0, c[31:16]}, 32'h0000_FFFF);
    check("R12 packet count below limit", {16'd0, c[15:0]}, 32'd32769);
    rd(3'd5, d); check("R6 clean single-beat packets", d, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule